// File: doc/BRIEF.md
# LED Brightness Fade Engine

This block holds the brightness setting of a group of LED current sinks and decides which 5-bit brightness code is applied to them at each moment. A register write carries a target code, a fade enable and a 2-bit rate select. If fading is off, the applied code takes the target on the writing clock edge. If fading is on, the applied code walks toward the target by one code per step. The step interval is a whole number of milliseconds. It is timed from a millisecond tick that the block divides down from its own clock.

The block also converts the applied code into a sink current in units of 0.5 mA. The current steps are not uniform: they are fine at low codes and coarser at the top. While a fade is running, the target is locked. A later write may still change the step rate, or cancel the fade by clearing the enable. A busy output shows when a fade is in progress.

Top module: `led_fade_engine`

## Requirements
- R1: After a synchronous active-low reset, `applied_code` is 0, fading is disabled, `level_half_ma` is 1 and `fade_busy` is 0.
- R2: A write (`wr_en` high) with `wr_fade_en` = 0 loads `wr_code` into both the target and `applied_code` on the writing edge.
- R3: With fading enabled, `applied_code` changes by exactly one code per step. It counts up when the target is above it and down when the target is below it, and it stops when it equals the target.
- R4: The step interval is (4 − `wr_rate`) × 8 ms: 0 → 32 ms, 1 → 24 ms, 2 → 16 ms, 3 → 8 ms. One ms is CLKS_PER_MS clocks. The first step lands interval × CLKS_PER_MS + 1 clock edges after the edge that accepted the target, and each later step lands interval × CLKS_PER_MS edges after the one before it.
- R5: A write during a fade always updates the rate. The step already being timed keeps its interval, and every step after it uses the new interval.
- R6: A write with `wr_fade_en` = 1 while `fade_busy` is high leaves the target unchanged, so the fade still ends on the old target.
- R7: A write with `wr_fade_en` = 0 during a fade sets `applied_code` to `wr_code` on the writing edge, and `fade_busy` drops.
- R8: `level_half_ma` is code + 1 for codes 0 to 23. It is 26, 28 and 30 for codes 24 to 26, and 34, 38, 42, 46 and 50 for codes 27 to 31.
- R9: `fade_busy` is high exactly when fading is enabled and `applied_code` differs from the target.
- R10: A write with fading enabled whose code equals `applied_code` starts no fade: no step occurs and `fade_busy` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_code | input | 5 | Requested brightness code |
| wr_fade_en | input | 1 | Fade enable carried by the write |
| wr_rate | input | 2 | Step-rate select carried by the write |
| applied_code | output | 5 | Brightness code currently driven to the sinks |
| level_half_ma | output | 6 | Sink current of the applied code in 0.5 mA units |
| fade_busy | output | 1 | High while a fade is in progress |

## Verification
The hardest case to reach is a rate change that arrives in the middle of a step interval. The port-visible proof is the spacing between later code changes, not the code values. The bench starts a fade at the fastest rate and then, halfway through the first interval, rewrites the register with the slowest rate and a different code. The scoreboard expects the first step at the old spacing, every later step at the new spacing, and the original target as the end point. A second fade is cancelled between two steps, to check that the immediate load wins over the pending step.

// File: rtl/led_fade_pkg.sv
// Package: shared widths, types and the rate-to-interval rule of the fade engine.
// Assumes: 5-bit brightness codes and a 2-bit rate select.
package led_fade_pkg;
    localparam int CODE_W  = 5;
    localparam int LEVEL_W = 6;
    localparam int RATE_W  = 2;
    localparam int RATE_STEPS = 1 << RATE_W;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [LEVEL_W-1:0] level_t;
    typedef logic [RATE_W-1:0]  rate_t;

    // Interval in ms for a rate select: higher select means shorter interval.
    function automatic int rate_to_ms(rate_t rate, int unit_ms);
        return (RATE_STEPS - int'(rate)) * unit_ms;
    endfunction
endpackage

// File: rtl/ms_tick_gen.sv
// Module: divides the clock into a one-cycle millisecond tick.
// Assumes: CLKS_PER_MS >= 1; clear realigns the tick phase so that a
// tick falls exactly CLKS_PER_MS cycles after the clear.
module ms_tick_gen #(
    parameter int CLKS_PER_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int DIV_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_MS - 1);

    logic [DIV_W-1:0] div_q;

    // Tick whenever the divider sits on its last count and is not being cleared.
    assign tick = !clear && (div_q == DIV_LAST);

    // Divider counter: wraps on the tick and restarts on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/fade_step_timer.sv
// Module: counts millisecond ticks and pulses a step after each interval.
// Assumes: the interval is sampled from the rate input on restart and at each
// step, so a rate change takes effect from the interval after the current one.
module fade_step_timer
    import led_fade_pkg::*;
#(
    parameter int UNIT_MS = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  logic  run,
    input  logic  ms_tick,
    input  rate_t rate,
    output logic  step
);
    localparam int MS_MAX = RATE_STEPS * UNIT_MS;
    localparam int MS_W   = $clog2(MS_MAX + 1);

    logic [MS_W-1:0] ms_q;
    logic [MS_W-1:0] interval_q;
    logic [MS_W-1:0] interval_next;

    // Interval length for the rate currently programmed.
    assign interval_next = MS_W'(rate_to_ms(rate, UNIT_MS));

    // A step closes an interval on its last millisecond tick.
    assign step = run && !restart && ms_tick && (ms_q == interval_q - 1'b1);

    // Millisecond counter and latched interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_q       <= '0;
            interval_q <= MS_W'(MS_MAX);
        end else if (restart || step) begin
            ms_q       <= '0;
            interval_q <= interval_next;
        end else if (run && ms_tick) begin
            ms_q <= ms_q + 1'b1;
        end
    end
endmodule

// File: rtl/fade_level_ctrl.sv
// Module: holds the setting register and moves the applied code to the target.
// Assumes: writes are single-cycle strobes; steps come from fade_step_timer.
module fade_level_ctrl
    import led_fade_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  code_t wr_code,
    input  logic  wr_fade_en,
    input  rate_t wr_rate,
    input  logic  step_i,
    output code_t applied_o,
    output rate_t rate_o,
    output logic  restart_o,
    output logic  busy_o
);
    code_t target_q;
    code_t applied_q;
    rate_t rate_q;
    logic  fade_en_q;
    logic  restart_q;
    logic  going_up;

    assign busy_o    = fade_en_q && (applied_q != target_q);
    assign going_up  = target_q > applied_q;
    assign applied_o = applied_q;
    assign rate_o    = rate_q;
    assign restart_o = restart_q;

    // Setting register, target lock and one-code stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q  <= '0;
            applied_q <= '0;
            rate_q    <= '0;
            fade_en_q <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            if (wr_en) begin
                fade_en_q <= wr_fade_en;
                rate_q    <= wr_rate;
            end
            if (wr_en && !wr_fade_en) begin
                target_q  <= wr_code;
                applied_q <= wr_code;
            end else begin
                if (wr_en && !busy_o) begin
                    target_q  <= wr_code;
                    restart_q <= (wr_code != applied_q);
                end
                if (step_i && busy_o) begin
                    applied_q <= going_up ? applied_q + 1'b1 : applied_q - 1'b1;
                end
            end
        end
    end

    // R2 / R7: a write with fading disabled loads the code at once and ends any fade.
    a_r7_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_fade_en) |=> (applied_q == $past(wr_code)) && !busy_o);

    // R6: a fade-enabled write while busy leaves the target alone.
    a_r6_target_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && wr_en && wr_fade_en) |=> (target_q == $past(target_q)));

    // R3: without a write, the applied code moves by at most one code.
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (applied_q == $past(applied_q))
                || (applied_q == CODE_W'($past(applied_q) + 1'b1))
                || (applied_q == CODE_W'($past(applied_q) - 1'b1)));

    // R3 / R4: the applied code only moves on a write or a timer step.
    a_r4_no_step_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !step_i) |=> $stable(applied_q));
endmodule

// File: rtl/code_to_level.sv
// Module: maps a brightness code to sink current in 0.5 mA units.
// Assumes: fine steps up to code 23, 1 mA steps up to 26, 2 mA steps above.
module code_to_level
    import led_fade_pkg::*;
(
    input  code_t  code,
    output level_t level
);
    localparam int FINE_END   = 24;
    localparam int MID_END    = 27;
    localparam int MID_BASE   = 26;
    localparam int COARSE_BASE = 34;

    // Piecewise-linear segments of the current curve.
    always_comb begin
        if (int'(code) < FINE_END) begin
            level = LEVEL_W'(int'(code) + 1);
        end else if (int'(code) < MID_END) begin
            level = LEVEL_W'(MID_BASE + 2 * (int'(code) - FINE_END));
        end else begin
            level = LEVEL_W'(COARSE_BASE + 4 * (int'(code) - MID_END));
        end
    end

    // R8: the current stays within 0.5 mA .. 25 mA for every code.
    always_comb begin
        a_r8_level_range: assert (level >= LEVEL_W'(1) && level <= LEVEL_W'(50));
    end
endmodule

// File: rtl/led_fade_engine.sv
// Module: top of the fade engine; wires tick divider, step timer, level
// controller and current map. Assumes a single clock and synchronous reset.
module led_fade_engine
    import led_fade_pkg::*;
#(
    parameter int CLKS_PER_MS = 1000,
    parameter int UNIT_MS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [4:0] wr_code,
    input  logic       wr_fade_en,
    input  logic [1:0] wr_rate,
    output logic [4:0] applied_code,
    output logic [5:0] level_half_ma,
    output logic       fade_busy
);
    logic  ms_tick;
    logic  step;
    logic  restart;
    rate_t rate;
    code_t applied;

    ms_tick_gen #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .tick  (ms_tick)
    );

    fade_step_timer #(.UNIT_MS(UNIT_MS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (fade_busy),
        .ms_tick (ms_tick),
        .rate    (rate),
        .step    (step)
    );

    fade_level_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_code    (wr_code),
        .wr_fade_en (wr_fade_en),
        .wr_rate    (wr_rate),
        .step_i     (step),
        .applied_o  (applied),
        .rate_o     (rate),
        .restart_o  (restart),
        .busy_o     (fade_busy)
    );

    code_to_level u_map (
        .code  (applied),
        .level (level_half_ma)
    );

    assign applied_code = applied;

    // R9: busy never stays high once the applied code reaches the target region via a direct load.
    a_r9_busy_clears_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_fade_en) |=> !fade_busy);
endmodule

// File: tb/led_fade_engine_tb.sv
// Scoreboard bench: scenario code pushes expected code changes with the edge
// on which each must occur; a monitor pops and compares them.
module led_fade_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MS_CLKS    = 4;
    localparam int WD_LIMIT   = 20000;

    typedef struct {
        logic [4:0] code;
        int         cyc;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_code = '0;
    logic       wr_fade_en = 1'b0;
    logic [1:0] wr_rate = '0;
    logic [4:0] applied_code;
    logic [5:0] level_half_ma;
    logic       fade_busy;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    exp_t exp_q[$];
    logic [4:0] last_seen = '0;
    logic [4:0] model_code = '0;

    led_fade_engine #(.CLKS_PER_MS(MS_CLKS), .UNIT_MS(8)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_code       (wr_code),
        .wr_fade_en    (wr_fade_en),
        .wr_rate       (wr_rate),
        .applied_code  (applied_code),
        .level_half_ma (level_half_ma),
        .fade_busy     (fade_busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Independent current model from R8, in 0.5 mA units.
    function automatic int exp_level(input int code);
        case (code)
            24: return 26;
            25: return 28;
            26: return 30;
            27: return 34;
            28: return 38;
            29: return 42;
            30: return 46;
            31: return 50;
            default: return code + 1;
        endcase
    endfunction

    task automatic push(input logic [4:0] code, input int at);
        exp_t e;
        e.code = code;
        e.cyc  = at;
        exp_q.push_back(e);
    endtask

    // Drive a write at the current negedge; returns the edge that samples it.
    task automatic start_write(input logic [4:0] code, input logic en,
                               input logic [1:0] rate, output int wedge);
        wr_code    = code;
        wr_fade_en = en;
        wr_rate    = rate;
        wr_en      = 1'b1;
        wedge      = cyc + 1;
    endtask

    task automatic finish_write();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Monitor: every change of the applied code must match the next expected item.
    always @(negedge clk) begin
        if (rst_n && applied_code !== last_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected change", int'(applied_code), int'(last_seen));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(applied_code == e.code, "R3 code", int'(applied_code), int'(e.code));
                check(cyc == e.cyc, "R4 timing", cyc, e.cyc);
            end
            last_seen = applied_code;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(negedge clk) begin
        if (cyc >= WD_LIMIT) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int w;
        int t;
        int per;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(applied_code == 5'd0, "R1 applied", int'(applied_code), 0);
        check(level_half_ma == 6'd1, "R1 level", int'(level_half_ma), 1);
        check(fade_busy == 1'b0, "R1 busy", int'(fade_busy), 0);

        // R2 / R8: immediate loads across every code, current checked per code
        for (int c = 0; c < 32; c++) begin
            start_write(5'(c), 1'b0, 2'b00, w);
            if (5'(c) != model_code) push(5'(c), w);
            model_code = 5'(c);
            finish_write();
            check(int'(level_half_ma) == exp_level(c), "R8 level", int'(level_half_ma), exp_level(c));
            check(fade_busy == 1'b0, "R2 busy", int'(fade_busy), 0);
        end

        // R2: immediate load down to 10
        start_write(5'd10, 1'b0, 2'b11, w);
        push(5'd10, w);
        finish_write();

        // R3 / R4 / R5 / R6: fade up 10 -> 14 at 8 ms, rate rewritten to 32 ms mid-step
        start_write(5'd14, 1'b1, 2'b11, w);
        t = w + 1 + 8 * MS_CLKS;
        push(5'd11, t);
        per = 32 * MS_CLKS;
        push(5'd12, t + per);
        push(5'd13, t + 2 * per);
        push(5'd14, t + 3 * per);
        finish_write();
        check(fade_busy == 1'b1, "R9 busy during fade", int'(fade_busy), 1);
        wait_until(w + 4 * MS_CLKS);
        start_write(5'd0, 1'b1, 2'b00, w);   // R6 code ignored, R5 rate taken
        finish_write();
        wait_until(t + 3 * per + 2);
        check(applied_code == 5'd14, "R6 final target", int'(applied_code), 14);
        check(fade_busy == 1'b0, "R9 busy after fade", int'(fade_busy), 0);

        // R3 down / R7: fade 14 -> 11 at 16 ms, cancelled after two steps
        start_write(5'd11, 1'b1, 2'b10, w);
        t = w + 1 + 16 * MS_CLKS;
        push(5'd13, t);
        push(5'd12, t + 16 * MS_CLKS);
        finish_write();
        wait_until(t + 16 * MS_CLKS + 5);
        start_write(5'd3, 1'b0, 2'b10, w);
        push(5'd3, w);
        finish_write();
        check(applied_code == 5'd3, "R7 cancel value", int'(applied_code), 3);
        check(fade_busy == 1'b0, "R7 busy dropped", int'(fade_busy), 0);

        // R10: fade-enabled write of the current code starts nothing
        start_write(5'd3, 1'b1, 2'b11, w);
        finish_write();
        check(fade_busy == 1'b0, "R10 busy", int'(fade_busy), 0);
        wait_until(w + 8 * MS_CLKS + 10);
        check(applied_code == 5'd3, "R10 no step", int'(applied_code), 3);

        // R4: 24 ms rate, fade 3 -> 5
        start_write(5'd5, 1'b1, 2'b01, w);
        t = w + 1 + 24 * MS_CLKS;
        push(5'd4, t);
        push(5'd5, t + 24 * MS_CLKS);
        finish_write();
        wait_until(t + 24 * MS_CLKS + 40);
        check(applied_code == 5'd5, "R4 24ms end", int'(applied_code), 5);
        check(int'(level_half_ma) == exp_level(5), "R8 level after fade",
              int'(level_half_ma), exp_level(5));

        check(exp_q.size() == 0, "R3 missing changes", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule